// File: doc/BRIEF.md
# Flash Block Erase Command Sequencer

This controller sits between a processor write bus and a flash array model. It watches bus writes for a two-write erase command: a setup byte followed by a confirm byte. When the pair is valid and the target block is not locked, it runs a timed erase phase and then a timed verify phase. Both phases are modelled as cycle counts. While the operation runs, it drives an erase strobe and a block index toward the array.

As soon as the confirm write is taken, reads return a status byte instead of array data. The status byte carries a ready flag, a suspended flag, an erase-result flag and a command-sequence error flag. Reads keep returning the status byte until software writes the read-array command. A level input pauses the erase counting, and dropping it resumes counting where it stopped. A clear-status command wipes both error flags.

Two inputs stand in for the array. A per-block lock vector refuses erase requests, and a verify-fail input marks the result of a finished verify as bad.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset: ready=1, suspended=0, both error flags 0, erase_active=0, and bus_rdata equals arr_rdata (array read mode).
- R2: A write of byte 0x20 to any even address, followed by the next write of byte 0xD0 to the top even address of block b (address bits [BLK_OFF_W-1:1] all ones, bit 0 zero), starts an erase of block b: ready drops to 0 and erase_blk reads b.
- R3: A write to an odd address while no setup is pending is ignored: no command is taken, and a following 0xD0 write neither starts an erase nor raises an error.
- R4: Without suspension, ready stays 0 for exactly ERASE_CYC+VERIFY_CYC cycles. erase_active is 1 during the first ERASE_CYC of these cycles and 0 during the verify cycles.
- R5: From the confirm write on, bus_rdata is the status byte in bits [7:0], with zeros above. The bit layout is: bit 7 ready, bit 6 suspended, bit 5 erase-result error, bit 4 sequence error, bits 3:0 zero.
- R6: Status read mode persists until byte 0xFF is written to an even address while idle. After that, bus_rdata returns arr_rdata.
- R7: A valid confirm aimed at a block whose erase_lock bit is set starts no erase (ready stays 1, erase_active stays 0) and sets the erase-result flag.
- R8: If the write after a setup is not 0xD0, or goes to an odd address, or goes to an address other than a block's top even address, no erase starts, the sequence error flag is set and status mode is entered.
- R9: Byte 0x50 written to an even address while idle clears both error flags and leaves ready unchanged.
- R10: While busy, a held suspend_req freezes the phase count; suspended reads 1 from the cycle after suspend_req is first sampled, erase_active reads 0 while suspended, and the operation lasts one cycle longer for every cycle suspend_req was sampled high.
- R11: If verify_fail is high on the final verify cycle, the erase-result flag is 1 once ready returns.
- R12: Bus writes while busy are ignored: they neither leave status mode nor arm a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the write |
| bus_wdata | input | 8 | Command byte lane of the write |
| bus_rdata | output | DATA_W | Read data: status byte or array data |
| arr_rdata | input | DATA_W | Data read from the array |
| erase_lock | input | NUM_BLK | Per-block erase refusal |
| verify_fail | input | 1 | Injected verify failure |
| suspend_req | input | 1 | Level request to suspend the erase |
| erase_active | output | 1 | Array erase strobe (erase phase, not suspended) |
| erase_blk | output | BLK_W | Index of the block being erased |
| ready | output | 1 | 1 when idle, 0 during erase and verify |
| suspended | output | 1 | 1 while the running operation is frozen |
| erase_err | output | 1 | Erase-result error flag |
| seq_err | output | 1 | Command-sequence error flag |

## Verification
The hardest situation to reach is a suspension that lands in the middle of the erase phase and is held for a known number of sampled edges. The test must then show that the whole operation stretches by exactly that count, with no drift of one cycle. The stimulus starts an erase and lets it run ten cycles. It then holds suspend_req for twenty clock edges, and the total time until ready returns must be eighty plus twenty cycles. A behavioural model, built on a single remaining-cycles integer, follows every cycle of this sequence. Tightly placed write pairs also cover malformed confirms, writes to locked blocks, and writes made while the controller is busy.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_VERIFY} phase_e;

  localparam logic [7:0] CMD_SETUP   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_RDARRAY = 8'hFF;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;

  localparam int ST_READY = 7;
  localparam int ST_SUSP  = 6;
  localparam int ST_EERR  = 5;
  localparam int ST_SERR  = 4;
endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
  import fes_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BLK_OFF_W = 8,
  localparam int BLK_W    = ADDR_W - BLK_OFF_W,
  localparam int NUM_BLK  = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic [NUM_BLK-1:0] lock,
  output logic              start,
  output logic              locked_hit,
  output logic              bad_seq,
  output logic              confirm_cyc,
  output logic              rd_array,
  output logic              clr_status,
  output logic [BLK_W-1:0]  blk_q
);
  logic             armed_q, armed_d;
  logic [BLK_W-1:0] blk_d;
  logic             accept, even, top_hit;
  logic [BLK_W-1:0] blk_idx;

  assign accept  = we && !busy;
  assign even    = !addr[0];
  assign top_hit = &addr[BLK_OFF_W-1:1];
  assign blk_idx = addr[ADDR_W-1:BLK_OFF_W];

  always_comb begin
    armed_d     = armed_q;
    blk_d       = blk_q;
    start       = 1'b0;
    locked_hit  = 1'b0;
    bad_seq     = 1'b0;
    confirm_cyc = 1'b0;
    rd_array    = 1'b0;
    clr_status  = 1'b0;
    if (accept && armed_q) begin
      armed_d     = 1'b0;
      confirm_cyc = 1'b1;
      if (even && top_hit && wdata == CMD_CONFIRM) begin
        if (lock[blk_idx]) begin
          locked_hit = 1'b1;
        end else begin
          start = 1'b1;
          blk_d = blk_idx;
        end
      end else begin
        bad_seq = 1'b1;
      end
    end else if (accept && even) begin
      case (wdata)
        CMD_SETUP:   armed_d    = 1'b1;
        CMD_RDARRAY: rd_array   = 1'b1;
        CMD_CLRSTAT: clr_status = 1'b1;
        default:     armed_d    = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      blk_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (start) blk_q <= blk_d;
    end
  end

  AST_ODD_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[0] && !armed_q) |=> !armed_q);  // R3
  AST_BUSY_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !armed_q);  // R12
endmodule

// File: rtl/fes_phase_timer.sv
module fes_phase_timer
  import fes_pkg::*;
#(
  parameter int ERASE_CYC  = 64,
  parameter int VERIFY_CYC = 16,
  localparam int MAX_CYC   = (ERASE_CYC > VERIFY_CYC) ? ERASE_CYC : VERIFY_CYC,
  localparam int CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic freeze,
  output logic busy,
  output logic busy_nxt,
  output logic erasing,
  output logic done
);
  localparam logic [CNT_W-1:0] ERASE_LAST  = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] VERIFY_LAST = CNT_W'(VERIFY_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ERASE;
          cnt_d   = '0;
        end
      end
      PH_ERASE: begin
        if (!freeze) begin
          if (cnt_q == ERASE_LAST) begin
            phase_d = PH_VERIFY;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_VERIFY: begin
        if (!freeze) begin
          if (cnt_q == VERIFY_LAST) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
            done    = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign busy_nxt = (phase_d != PH_IDLE);
  assign erasing  = (phase_q == PH_ERASE);

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && freeze) |=> ($stable(cnt_q) && $stable(phase_q)));  // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R4
  AST_START_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase_q == PH_ERASE && cnt_q == '0));  // R2
endmodule

// File: rtl/fes_status.sv
module fes_status (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic busy_nxt,
  input  logic suspend_req,
  input  logic confirm_cyc,
  input  logic locked_hit,
  input  logic bad_seq,
  input  logic done,
  input  logic verify_fail,
  input  logic rd_array,
  input  logic clr_status,
  output logic stat_mode_q,
  output logic susp_q,
  output logic eerr_q,
  output logic serr_q
);
  logic stat_mode_d, susp_d, eerr_d, serr_d;

  always_comb begin
    stat_mode_d = stat_mode_q;
    if (confirm_cyc)   stat_mode_d = 1'b1;
    else if (rd_array) stat_mode_d = 1'b0;

    susp_d = suspend_req && busy_nxt;

    eerr_d = eerr_q;
    if (clr_status) eerr_d = 1'b0;
    else if (locked_hit || (done && verify_fail)) eerr_d = 1'b1;

    serr_d = serr_q;
    if (clr_status)   serr_d = 1'b0;
    else if (bad_seq) serr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_mode_q <= 1'b0;
      susp_q      <= 1'b0;
      eerr_q      <= 1'b0;
      serr_q      <= 1'b0;
    end else begin
      stat_mode_q <= stat_mode_d;
      susp_q      <= susp_d;
      eerr_q      <= eerr_d;
      serr_q      <= serr_d;
    end
  end

  AST_SUSP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> busy);  // R10
  AST_CONFIRM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_cyc |=> stat_mode_q);  // R5
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_mode_q && !rd_array) |=> stat_mode_q);  // R6
  AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    locked_hit |=> eerr_q);  // R7
  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bad_seq |=> serr_q);  // R8
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |=> (!eerr_q && !serr_q));  // R9
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BLK_OFF_W  = 8,
  parameter int DATA_W     = 16,
  parameter int ERASE_CYC  = 64,
  parameter int VERIFY_CYC = 16,
  localparam int BLK_W     = ADDR_W - BLK_OFF_W,
  localparam int NUM_BLK   = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [DATA_W-1:0]  arr_rdata,
  input  logic [NUM_BLK-1:0] erase_lock,
  input  logic               verify_fail,
  input  logic               suspend_req,
  output logic               erase_active,
  output logic [BLK_W-1:0]   erase_blk,
  output logic               ready,
  output logic               suspended,
  output logic               erase_err,
  output logic               seq_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic start, locked_hit, bad_seq, confirm_cyc, rd_array, clr_status;
  logic busy, busy_nxt, erasing, done;
  logic stat_mode, susp_q, eerr_q, serr_q;
  logic [7:0] stat_byte;

  fes_cmd_decode #(.ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W)) u_decode (
    .clk(clk), .rst_n(rst_int_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .busy(busy), .lock(erase_lock), .start(start), .locked_hit(locked_hit),
    .bad_seq(bad_seq), .confirm_cyc(confirm_cyc), .rd_array(rd_array),
    .clr_status(clr_status), .blk_q(erase_blk)
  );

  fes_phase_timer #(.ERASE_CYC(ERASE_CYC), .VERIFY_CYC(VERIFY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .start(start), .freeze(susp_q),
    .busy(busy), .busy_nxt(busy_nxt), .erasing(erasing), .done(done)
  );

  fes_status u_status (
    .clk(clk), .rst_n(rst_int_n), .busy(busy), .busy_nxt(busy_nxt),
    .suspend_req(suspend_req), .confirm_cyc(confirm_cyc), .locked_hit(locked_hit),
    .bad_seq(bad_seq), .done(done), .verify_fail(verify_fail), .rd_array(rd_array),
    .clr_status(clr_status), .stat_mode_q(stat_mode), .susp_q(susp_q),
    .eerr_q(eerr_q), .serr_q(serr_q)
  );

  always_comb begin
    stat_byte           = '0;
    stat_byte[ST_READY] = !busy;
    stat_byte[ST_SUSP]  = susp_q;
    stat_byte[ST_EERR]  = eerr_q;
    stat_byte[ST_SERR]  = serr_q;
  end

  assign bus_rdata    = stat_mode ? {{(DATA_W-8){1'b0}}, stat_byte} : arr_rdata;
  assign ready        = !busy;
  assign suspended    = susp_q;
  assign erase_err    = eerr_q;
  assign seq_err      = serr_q;
  assign erase_active = erasing && !susp_q;

  AST_LOCK_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    locked_hit |=> (ready && !erase_active));  // R7
  AST_VFAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && verify_fail) |=> (ready && erase_err));  // R11
  AST_ABORT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    bad_seq |=> ready);  // R8
endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
  localparam int ADDR_W = 12, BLK_OFF_W = 8, DATA_W = 16;
  localparam int EC = 64, VC = 16;
  localparam int BLK_W = ADDR_W - BLK_OFF_W, NUM_BLK = 1 << BLK_W;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata, arr_rdata;
  logic [NUM_BLK-1:0] erase_lock;
  logic verify_fail, suspend_req;
  logic erase_active, ready, suspended, erase_err, seq_err;
  logic [BLK_W-1:0] erase_blk;

  always #5 clk = ~clk;

  flash_erase_seq #(.ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .DATA_W(DATA_W),
                    .ERASE_CYC(EC), .VERIFY_CYC(VC)) u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_rdata(arr_rdata),
    .erase_lock(erase_lock), .verify_fail(verify_fail), .suspend_req(suspend_req),
    .erase_active(erase_active), .erase_blk(erase_blk), .ready(ready),
    .suspended(suspended), .erase_err(erase_err), .seq_err(seq_err)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done_run = 0;

  // behavioural reference state
  bit m_rs1 = 0, m_rs2 = 0;
  bit m_armed = 0, m_busy = 0, m_susp = 0, m_stat = 0, m_eerr = 0, m_serr = 0;
  int m_remain = 0;
  int m_blk = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0;
      m_armed = 0; m_busy = 0; m_susp = 0; m_stat = 0; m_eerr = 0; m_serr = 0; m_remain = 0;
    end else begin
      if (m_rs2) begin
        if (m_busy) begin
          if (!m_susp) begin
            m_remain--;
            if (m_remain == 0) begin
              m_busy = 0;
              if (verify_fail) m_eerr = 1;
            end
          end
        end else if (bus_we) begin
          if (m_armed) begin
            m_armed = 0;
            m_stat = 1;
            if (!bus_addr[0] && (bus_addr[BLK_OFF_W-1:0] == 8'hFE) && bus_wdata == 8'hD0) begin
              if (erase_lock[bus_addr[ADDR_W-1:BLK_OFF_W]]) m_eerr = 1;
              else begin
                m_busy = 1; m_remain = EC + VC;
                m_blk = int'(bus_addr[ADDR_W-1:BLK_OFF_W]);
              end
            end else m_serr = 1;
          end else if (!bus_addr[0]) begin
            if (bus_wdata == 8'h20) m_armed = 1;
            else if (bus_wdata == 8'hFF) m_stat = 0;
            else if (bus_wdata == 8'h50) begin m_eerr = 0; m_serr = 0; end
          end
        end
        m_susp = suspend_req && m_busy;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
    if (cyc > 20000 && !done_run) begin
      fails++;
      $display("FAIL R4 watchdog: operation hung actual=%0d expected<=%0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    logic [DATA_W-1:0] exp_rd;
    exp_rd = m_stat ? DATA_W'({!m_busy, m_susp, m_eerr, m_serr, 4'b0000}) : arr_rdata;
    chk("R4 ready", ready, !m_busy);
    chk("R10 suspended", suspended, m_susp);
    chk("R7 erase_err", erase_err, m_eerr);
    chk("R8 seq_err", seq_err, m_serr);
    chk("R2 erase_active", erase_active, m_busy && !m_susp && (m_remain > VC));
    chk("R5 bus_rdata", bus_rdata, exp_rd);
    if (m_busy) chk("R2 erase_blk", erase_blk, m_blk);
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 0;
  endtask

  task automatic wait_ready(output int c);
    c = 0;
    @(negedge clk);
    while (!ready && c < 2000) begin c++; @(negedge clk); end
  endtask

  function automatic logic [ADDR_W-1:0] top_of(input int b);
    return ADDR_W'((b << BLK_OFF_W) | ((1 << BLK_OFF_W) - 2));
  endfunction

  initial begin
    int n;
    int t0;
    rst_n = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    arr_rdata = 16'hA5C3; erase_lock = '0; verify_fail = 0; suspend_req = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 ready", ready, 1); chk("R1 rdata", bus_rdata, 16'hA5C3);
    chk("R1 err", {erase_err, seq_err, suspended, erase_active}, 0);

    // R2/R4/R5: normal erase of block 3
    wr(12'h100, 8'h20);
    wr(top_of(3), 8'hD0);
    @(negedge clk);
    chk("R2 busy", ready, 0); chk("R2 blk", erase_blk, 3);
    chk("R5 status busy", bus_rdata, 16'h0000);
    wait_ready(n);
    chk("R4 busy length", n + 1, EC + VC);
    chk("R5 status done", bus_rdata, 16'h0080);

    // R12: writes during busy ignored
    wr(12'h000, 8'h20);
    wr(top_of(1), 8'hD0);
    wr(12'h010, 8'hFF);
    wr(12'h010, 8'h20);
    @(negedge clk);
    chk("R12 still status", bus_rdata, 16'h0000);
    wait_ready(n);
    wr(top_of(1), 8'hD0);
    @(negedge clk);
    chk("R12 no arm", {ready, seq_err}, 2'b10);

    // R6: read array
    wr(12'h020, 8'hFF);
    arr_rdata = 16'h3C5A;
    @(negedge clk);
    chk("R6 array read", bus_rdata, 16'h3C5A);

    // R3: odd-address setup ignored
    wr(12'h101, 8'h20);
    wr(top_of(5), 8'hD0);
    @(negedge clk);
    chk("R3 odd ignored", {ready, seq_err, erase_err}, 3'b100);
    chk("R3 still array", bus_rdata, 16'h3C5A);

    // R8: malformed confirms, with R9 clear between
    wr(12'h100, 8'h20); wr(top_of(5), 8'h40);
    @(negedge clk); chk("R8 bad byte", {ready, seq_err}, 2'b11);
    chk("R8 status entered", bus_rdata, 16'h0090);
    wr(12'h100, 8'h50);
    @(negedge clk); chk("R9 clear", {ready, seq_err, erase_err}, 3'b100);
    wr(12'h100, 8'h20); wr(12'h5FC, 8'hD0);
    @(negedge clk); chk("R8 not top", {ready, seq_err}, 2'b11);
    wr(12'h100, 8'h50);
    wr(12'h100, 8'h20); wr(12'h5FF, 8'hD0);
    @(negedge clk); chk("R8 odd confirm", {ready, seq_err}, 2'b11);
    wr(12'h100, 8'h50);

    // R7: locked block
    erase_lock[6] = 1;
    wr(12'h100, 8'h20); wr(top_of(6), 8'hD0);
    @(negedge clk); chk("R7 locked", {ready, erase_active, erase_err}, 3'b101);
    wr(12'h100, 8'h50);
    @(negedge clk); chk("R9 ready kept", {ready, erase_err}, 2'b10);
    erase_lock = '0;

    // R10: suspend for 20 edges mid-erase
    wr(12'h100, 8'h20); wr(top_of(2), 8'hD0);
    t0 = cyc;
    repeat (10) @(posedge clk);
    #2 suspend_req = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 suspended", {suspended, erase_active, ready}, 3'b100);
    chk("R10 status susp", bus_rdata, 16'h0040);
    repeat (17) @(posedge clk);
    #2 suspend_req = 0;
    wait_ready(n);
    chk("R10 stretched", cyc - t0, EC + VC + 20);

    // R11: verify failure
    verify_fail = 1;
    wr(12'h100, 8'h20); wr(top_of(7), 8'hD0);
    wait_ready(n);
    chk("R11 verify fail", {ready, erase_err}, 2'b11);
    verify_fail = 0;
    wr(12'h100, 8'h50);
    wr(12'h100, 8'hFF);
    @(negedge clk);
    chk("R6 back to array", bus_rdata, 16'h3C5A);

    done_run = 1;
    summary();
    $finish;
  end
endmodule